// File: doc/BRIEF.md
# SPI Channel FIFO, Status and Interrupt Unit

This unit sits between a register bus and the shift engine of one SPI channel. It holds two word queues: one for transmit, filled by register writes and drained by the engine, and one for receive, filled by the engine and drained by register reads. It also holds the channel's status, interrupt enable and FIFO threshold registers. Both FIFO fill levels can be read back from one packed register.

The shift engine reports the end of a transfer, a transmit underflow and a receive overflow as one-cycle pulses. The unit latches these pulses into sticky status bits, and software clears them by writing ones. The two threshold status bits are live comparisons of each FIFO level against a programmed level. A single interrupt line is the OR of every status condition whose enable bit is set. The configuration, divider and command words are plain storage. They are read back on the bus and driven out to the engine.

Top module: `spi_fifo_status`

## Requirements
- R1: After reset both FIFO counts are 0, the sticky status bits, the interrupt enables, the threshold register and the configuration, divider and command words are 0, and irq is 0. Because both levels are 0, a status read returns 0x0C.
- R2: A write to offset 0x1C pushes the 32-bit write data into the 8-word transmit FIFO. A write while the FIFO holds 8 words is ignored: the count stays at 8 and the word is never delivered. Words leave in first-in first-out order.
- R3: An engRxPush pulse stores engRxWord in the 8-word receive FIFO, and the word is dropped if the FIFO is full. A read of offset 0x20 returns the oldest word and pops it. A read of an empty receive FIFO returns 0.
- R4: Offset 0x18 reads the receive count in bits [3:0] and the transmit count in bits [7:4], with all other bits 0.
- R5: Offset 0x0C reads the status word: bit0 transfer pending (equal to the xferPending input), bit1 done, bit2 transmit threshold, bit3 receive threshold, bit4 transmit underflow, bit5 receive overflow. Bits 31:6 read as 0.
- R6: Done, underflow and overflow are set by the evtDone, evtUnderflow and evtOverflow pulses and stay set until a write to 0x0C with a 1 in their bit position. A 0 in the write data leaves a bit unchanged. An event in the same cycle as its clear leaves the bit set.
- R7: Offset 0x14 holds the transmit level in bits [3:0] and the receive level in bits [7:4]. Status bit2 is 1 while the transmit count is at or below the transmit level. Status bit3 is 1 while the receive count is at or above the receive level. Writes to status bits 0, 2 and 3 have no effect.
- R8: Offset 0x10 holds the interrupt enables in bits [4:0]: bit0 enables done (status bit1), bit1 transmit threshold (bit2), bit2 receive threshold (bit3), bit3 underflow (bit4), bit4 overflow (bit5). irq is 1 exactly when some enabled status bit is 1. The pending bit is never an interrupt source.
- R9: Offsets 0x00, 0x04 and 0x08 store full 32-bit configuration, divider and command words. These read back unchanged and drive cfgWord, divWord and cmdWord.
- R10: engTxWord shows the oldest transmit word, or 0 when the FIFO is empty. engTxPop removes it, and a pop of an empty FIFO changes nothing. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (pops the receive FIFO at 0x20) |
| regAddr | input | 8 | Byte offset within the channel |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| engTxPop | input | 1 | Engine takes the oldest transmit word |
| engTxWord | output | 32 | Oldest transmit word, 0 when empty |
| engRxPush | input | 1 | Engine delivers a received word |
| engRxWord | input | 32 | Received word |
| evtDone | input | 1 | Transfer-done pulse |
| evtUnderflow | input | 1 | Transmit underflow pulse |
| evtOverflow | input | 1 | Receive overflow pulse |
| xferPending | input | 1 | Engine has a transfer in progress |
| cfgWord | output | 32 | Stored configuration word |
| divWord | output | 32 | Stored divider word |
| cmdWord | output | 32 | Stored command word |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is a sticky event that arrives in the same cycle as the software clear of its bit. The bench drives an overflow pulse and a status write with bit5 set on the same negative edge. It then reads the status to confirm that the bit survived. It also reaches both FIFO boundaries: it writes a ninth transmit word into a full queue, it pushes a ninth received word, and it reads past empty. In each case the bench checks the counts and the delivered order.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned FIFO_DEPTH = 8;
  localparam int unsigned ADDR_W     = 8;

  localparam logic [ADDR_W-1:0] OFS_CFG  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_DIV  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_CMD  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_THR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_WCNT = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_TXD  = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_RXD  = 8'h20;

  typedef struct packed {
    logic txPush;
    logic txPop;
    logic rxPush;
    logic rxPop;
  } fifoStrobe_t;
endpackage

// File: rtl/spi_word_fifo.sv
module spi_word_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign doPush = push && (count != CNT_W'(DEPTH));
  assign doPop  = pop && (count != '0);
  assign rdData = (count == '0) ? '0 : mem[rdPtr];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= wrData;
        wrPtr      <= nextPtr(wrPtr);
      end
      if (doPop) rdPtr <= nextPtr(rdPtr);
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/spi_fifo_dp.sv
module spi_fifo_dp
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobe_t       strobe,
  input  logic [DATA_W-1:0] txWrData,
  input  logic [DATA_W-1:0] rxWrData,
  output logic [DATA_W-1:0] txHead,
  output logic [DATA_W-1:0] rxHead,
  output logic [CNT_W-1:0]  txCount,
  output logic [CNT_W-1:0]  rxCount
);
  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(strobe.txPush), .pop(strobe.txPop),
    .wrData(txWrData), .rdData(txHead), .count(txCount)
  );

  spi_word_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(strobe.rxPush), .pop(strobe.rxPop),
    .wrData(rxWrData), .rdData(rxHead), .count(rxCount)
  );
endmodule

// File: rtl/spi_fifo_ctrl.sv
module spi_fifo_ctrl
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              engTxPop,
  input  logic              engRxPush,
  input  logic              evtDone,
  input  logic              evtUnderflow,
  input  logic              evtOverflow,
  input  logic              xferPending,
  input  logic [CNT_W-1:0]  txCount,
  input  logic [CNT_W-1:0]  rxCount,
  input  logic [DATA_W-1:0] rxHead,
  output fifoStrobe_t       strobe,
  output logic [DATA_W-1:0] cfgWord,
  output logic [DATA_W-1:0] divWord,
  output logic [DATA_W-1:0] cmdWord,
  output logic [DATA_W-1:0] statusWord,
  output logic [4:0]        ienWord,
  output logic              irq
);
  logic [7:0] thrQ;
  logic       doneQ, ufQ, ofQ;
  logic [3:0] txCnt4, rxCnt4;
  logic       txTh, rxTh;
  logic       wrStat;

  assign txCnt4 = 4'(txCount);
  assign rxCnt4 = 4'(rxCount);
  assign txTh   = txCnt4 <= thrQ[3:0];
  assign rxTh   = rxCnt4 >= thrQ[7:4];
  assign wrStat = regWrEn && (regAddr == OFS_STAT);

  assign strobe.txPush = regWrEn && (regAddr == OFS_TXD);
  assign strobe.txPop  = engTxPop;
  assign strobe.rxPush = engRxPush;
  assign strobe.rxPop  = regRdEn && (regAddr == OFS_RXD);

  assign statusWord = {26'b0, ofQ, ufQ, rxTh, txTh, doneQ, xferPending};
  assign irq = |(ienWord & statusWord[5:1]);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgWord <= '0;
      divWord <= '0;
      cmdWord <= '0;
      ienWord <= '0;
      thrQ    <= '0;
      doneQ   <= 1'b0;
      ufQ     <= 1'b0;
      ofQ     <= 1'b0;
    end else begin
      doneQ <= evtDone      || (doneQ && !(wrStat && regWrData[1]));
      ufQ   <= evtUnderflow || (ufQ   && !(wrStat && regWrData[4]));
      ofQ   <= evtOverflow  || (ofQ   && !(wrStat && regWrData[5]));
      if (regWrEn) begin
        case (regAddr)
          OFS_CFG: cfgWord <= regWrData;
          OFS_DIV: divWord <= regWrData;
          OFS_CMD: cmdWord <= regWrData;
          OFS_IEN: ienWord <= regWrData[4:0];
          OFS_THR: thrQ    <= regWrData[7:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regAddr)
      OFS_CFG:  regRdData = cfgWord;
      OFS_DIV:  regRdData = divWord;
      OFS_CMD:  regRdData = cmdWord;
      OFS_STAT: regRdData = statusWord;
      OFS_IEN:  regRdData = {27'b0, ienWord};
      OFS_THR:  regRdData = {24'b0, thrQ};
      OFS_WCNT: regRdData = {24'b0, txCnt4, rxCnt4};
      OFS_RXD:  regRdData = rxHead;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/spi_fifo_status.sv
module spi_fifo_status
  import spi_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = FIFO_DEPTH,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [7:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  input  logic        engTxPop,
  output logic [31:0] engTxWord,
  input  logic        engRxPush,
  input  logic [31:0] engRxWord,
  input  logic        evtDone,
  input  logic        evtUnderflow,
  input  logic        evtOverflow,
  input  logic        xferPending,
  output logic [31:0] cfgWord,
  output logic [31:0] divWord,
  output logic [31:0] cmdWord,
  output logic        irq
);
  fifoStrobe_t       strobe;
  logic [CNT_W-1:0]  txCount, rxCount;
  logic [DATA_W-1:0] rxHead;
  logic [DATA_W-1:0] statusWord;
  logic [4:0]        ienWord;

  spi_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engTxPop(engTxPop), .engRxPush(engRxPush), .evtDone(evtDone),
    .evtUnderflow(evtUnderflow), .evtOverflow(evtOverflow),
    .xferPending(xferPending), .txCount(txCount), .rxCount(rxCount),
    .rxHead(rxHead), .strobe(strobe), .cfgWord(cfgWord), .divWord(divWord),
    .cmdWord(cmdWord), .statusWord(statusWord), .ienWord(ienWord), .irq(irq)
  );

  spi_fifo_dp #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .txWrData(regWrData),
    .rxWrData(engRxWord), .txHead(engTxWord), .rxHead(rxHead),
    .txCount(txCount), .rxCount(rxCount)
  );
endmodule

// File: rtl/spi_fifo_status_chk.sv
module spi_fifo_status_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             regWrEn,
  input logic             regRdEn,
  input logic [7:0]       regAddr,
  input logic             wrClrDone,
  input logic [31:0]      regRdData,
  input logic             evtDone,
  input logic             engTxPop,
  input logic             irq,
  input logic [31:0]      statusWord,
  input logic [4:0]       ienWord,
  input logic [CNT_W-1:0] txCount,
  input logic [CNT_W-1:0] rxCount
);
  assert_done_sets_R6: assert property (@(posedge clk) disable iff (!rstN)
    evtDone |=> statusWord[1]);

  assert_done_clears_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 8'h0C && wrClrDone && !evtDone) |=> !statusWord[1]);

  assert_tx_bounded_R2: assert property (@(posedge clk) disable iff (!rstN)
    txCount <= CNT_W'(DEPTH));

  assert_full_push_ignored_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txCount == CNT_W'(DEPTH) && regWrEn && regAddr == 8'h1C && !engTxPop)
      |=> (txCount == CNT_W'(DEPTH)));

  assert_empty_read_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 8'h20 && rxCount == '0) |-> (regRdData == 32'h0));

  assert_status_upper_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 8'h0C) |-> (regRdData[31:6] == 26'h0));

  assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ienWord == 5'h0) |-> !irq);
endmodule

bind spi_fifo_status spi_fifo_status_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
  .regAddr(regAddr), .wrClrDone(regWrData[1]), .regRdData(regRdData),
  .evtDone(evtDone), .engTxPop(engTxPop), .irq(irq),
  .statusWord(statusWord), .ienWord(ienWord), .txCount(txCount),
  .rxCount(rxCount)
);

// File: tb/spi_fifo_status_bench.sv
module spi_fifo_status_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic        engTxPop = 1'b0, engRxPush = 1'b0;
  logic [31:0] engTxWord, engRxWord = '0;
  logic        evtDone = 1'b0, evtUnderflow = 1'b0, evtOverflow = 1'b0;
  logic        xferPending = 1'b0;
  logic [31:0] cfgWord, divWord, cmdWord;
  logic        irq;

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_fifo_status u_spi_fifo_status (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .engTxPop(engTxPop), .engTxWord(engTxWord), .engRxPush(engRxPush),
    .engRxWord(engRxWord), .evtDone(evtDone), .evtUnderflow(evtUnderflow),
    .evtOverflow(evtOverflow), .xferPending(xferPending), .cfgWord(cfgWord),
    .divWord(divWord), .cmdWord(cmdWord), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic regRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic engPush(input logic [31:0] w);
    @(negedge clk);
    engRxPush = 1'b1; engRxWord = w;
    @(negedge clk);
    engRxPush = 1'b0;
  endtask

  task automatic engPop(output logic [31:0] w);
    @(negedge clk);
    w = engTxWord;
    engTxPop = 1'b1;
    @(negedge clk);
    engTxPop = 1'b0;
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    evtDone = (which == 0); evtUnderflow = (which == 1); evtOverflow = (which == 2);
    @(negedge clk);
    evtDone = 0; evtUnderflow = 0; evtOverflow = 0;
  endtask

  task automatic testReset();
    logic [31:0] d;
    peek(8'h0C, d); check("R1 status after reset", d, 32'h0C);
    peek(8'h18, d); check("R1 counts after reset", d, 32'h0);
    peek(8'h10, d); check("R1 enables after reset", d, 32'h0);
    check("R1 irq after reset", {31'b0, irq}, 32'h0);
    check("R1 cfg after reset", cfgWord, 32'h0);
  endtask

  task automatic testTxFifo();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) regWrite(8'h1C, 32'hA000_0000 + i);
    peek(8'h18, d); check("R2 R4 tx count full", d, 32'h80);
    for (int i = 0; i < 8; i++) begin
      engPop(d); check("R2 tx order", d, 32'hA000_0000 + i);
    end
    #1 check("R10 tx empty word zero", engTxWord, 32'h0);
    engPop(d);
    peek(8'h18, d); check("R10 pop empty tx count", d, 32'h0);
    regWrite(8'h1C, 32'h1234_5678);
    #1 check("R2 R10 ninth word never delivered", engTxWord, 32'h1234_5678);
    engPop(d);
  endtask

  task automatic testRxFifo();
    logic [31:0] d;
    for (int i = 0; i < 9; i++) engPush(32'hB000_0000 + i);
    peek(8'h18, d); check("R3 R4 rx count full", d, 32'h08);
    for (int i = 0; i < 8; i++) begin
      regRead(8'h20, d); check("R3 rx order", d, 32'hB000_0000 + i);
    end
    regRead(8'h20, d); check("R3 empty rx read zero", d, 32'h0);
    peek(8'h18, d); check("R3 rx count empty", d, 32'h0);
  endtask

  task automatic testSticky();
    logic [31:0] d;
    pulse(0);
    peek(8'h0C, d); check("R6 done set", d & 32'h2, 32'h2);
    regWrite(8'h0C, 32'h0);
    peek(8'h0C, d); check("R6 write zero keeps done", d & 32'h2, 32'h2);
    regWrite(8'h0C, 32'h2);
    peek(8'h0C, d); check("R6 done cleared", d & 32'h2, 32'h0);
    pulse(1);
    peek(8'h0C, d); check("R6 underflow set", d & 32'h10, 32'h10);
    regWrite(8'h0C, 32'h10);
    @(negedge clk);
    evtOverflow = 1'b1; regWrEn = 1'b1; regAddr = 8'h0C; regWrData = 32'h20;
    @(negedge clk);
    evtOverflow = 1'b0; regWrEn = 1'b0; regWrData = '0;
    peek(8'h0C, d); check("R6 set wins over clear", d & 32'h30, 32'h20);
    regWrite(8'h0C, 32'hFFFF_FFFF);
    peek(8'h0C, d); check("R7 R5 status after clear all", d, 32'h0C);
    xferPending = 1'b1;
    peek(8'h0C, d); check("R5 pending follows input", d, 32'h0D);
    xferPending = 1'b0;
  endtask

  task automatic testThreshold();
    logic [31:0] d;
    regWrite(8'h14, 32'h32);
    peek(8'h0C, d); check("R7 tx below level", d & 32'hC, 32'h4);
    for (int i = 0; i < 3; i++) regWrite(8'h1C, i);
    peek(8'h0C, d); check("R7 tx above level", d & 32'h4, 32'h0);
    for (int i = 0; i < 3; i++) engPush(i);
    peek(8'h0C, d); check("R7 rx at level", d & 32'h8, 32'h8);
    regRead(8'h20, d);
    peek(8'h0C, d); check("R7 rx below level", d & 32'h8, 32'h0);
    for (int i = 0; i < 3; i++) engPop(d);
    for (int i = 0; i < 2; i++) regRead(8'h20, d);
  endtask

  task automatic testIrq();
    logic [31:0] d;
    regWrite(8'h14, 32'hF0);
    regWrite(8'h10, 32'h1F);
    peek(8'h0C, d); check("R8 status quiet", d, 32'h4);
    check("R8 tx threshold drives irq", {31'b0, irq}, 32'h1);
    regWrite(8'h10, 32'h11);
    xferPending = 1'b1;
    #1 check("R8 pending not a source", {31'b0, irq}, 32'h0);
    xferPending = 1'b0;
    pulse(2);
    #1 check("R8 overflow irq", {31'b0, irq}, 32'h1);
    regWrite(8'h10, 32'h01);
    #1 check("R8 overflow masked", {31'b0, irq}, 32'h0);
    pulse(0);
    #1 check("R8 done irq", {31'b0, irq}, 32'h1);
    regWrite(8'h0C, 32'h22);
    #1 check("R8 irq after clear", {31'b0, irq}, 32'h0);
    peek(8'h10, d); check("R8 enable readback", d, 32'h01);
  endtask

  task automatic testStorage();
    logic [31:0] d;
    regWrite(8'h00, 32'hDEAD_BEEF);
    regWrite(8'h04, 32'h0000_0104);
    regWrite(8'h08, 32'h00FF_0013);
    peek(8'h00, d); check("R9 cfg readback", d, 32'hDEAD_BEEF);
    peek(8'h04, d); check("R9 div readback", d, 32'h0000_0104);
    peek(8'h08, d); check("R9 cmd readback", d, 32'h00FF_0013);
    check("R9 cfg port", cfgWord, 32'hDEAD_BEEF);
    check("R9 div port", divWord, 32'h0000_0104);
    check("R9 cmd port", cmdWord, 32'h00FF_0013);
    regWrite(8'h40, 32'h5555_5555);
    peek(8'h40, d); check("R10 unmapped reads zero", d, 32'h0);
    peek(8'h00, d); check("R10 unmapped write harmless", d, 32'hDEAD_BEEF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTxFifo();
    testRxFifo();
    testSticky();
    testThreshold();
    testIrq();
    testStorage();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule